// File: doc/BRIEF.md
# Speculative Access Conflict Table

This block keeps a small, fully associative record of the cache lines a core has touched while running ahead of outstanding persist barriers. Each record holds the line address, whether the line was written, and the identifier of the speculative epoch that made the access. Every coherence probe arriving from another agent is compared against all records in parallel. When a probe would expose or disturb speculative state, the block raises a one-cycle abort request that names the epoch to roll back to.

Epoch identifiers are small counters that wrap around. The block keeps its own copy of the oldest live epoch, advanced by a commit pulse. It orders epochs by their distance from that oldest one, so wrap-around does not upset the ordering. A static parameter selects the rollback policy. In the coarse policy every conflict names the oldest live epoch. In the per-epoch policy a conflict names the oldest epoch that actually owns a conflicting record, so younger work is discarded and older work is kept.

The surrounding core drives accesses, probes, commits and aborts. It carries out the rollback itself, and reports it back through the abort input so the matching records are dropped.

Top module: `spec_conflict_table`

## Requirements
- R1: After reset the table is empty, `abort_req` is low and the oldest live epoch is 0.
- R2: A probe with `prb_excl` = 1 whose address equals that of any valid record causes `abort_req` = 1 in the next cycle.
- R3: A probe with `prb_excl` = 0 causes an abort only if a matching valid record has its written flag set; hits on records that were only read cause no abort.
- R4: A probe whose address matches no valid record causes no abort.
- R5: With `FINE_GRAIN` = 1 the abort target of a probe conflict is the conflicting epoch of least age, where age = (epoch - oldest) mod 2^EPOCH_W.
- R6: With `FINE_GRAIN` = 0 the abort target of a probe conflict is the oldest live epoch.
- R7: An access whose address and epoch equal those of a valid record makes no new record; a write sets that record's written flag, which then stays set.
- R8: `cmt_valid` drops every record of the oldest live epoch and advances the oldest epoch by one, wrapping modulo 2^EPOCH_W.
- R9: `abt_valid` drops every record whose age is at least the age of `abt_epoch`; records of older epochs remain.
- R10: An access that matches no record while all DEPTH records are valid is not stored and requests an abort of the access's own epoch. If a probe conflict occurs in the same cycle, the target is whichever of the two epochs has the smaller age.
- R11: An access in a cycle with `cmt_valid` or `abt_valid` is not recorded. A probe in any cycle is checked against the table as it stood before that cycle's update.
- R12: `abort_req` is high for exactly the cycles that follow a cycle with a conflict or a dropped access, and `abort_epoch` is valid while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Speculative access to record |
| acc_addr | input | ADDR_W | Line address of the access |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_epoch | input | EPOCH_W | Epoch making the access |
| prb_valid | input | 1 | External coherence probe present |
| prb_addr | input | ADDR_W | Line address of the probe |
| prb_excl | input | 1 | 1 = probe seeks exclusive ownership, 0 = shared |
| cmt_valid | input | 1 | Oldest live epoch commits |
| abt_valid | input | 1 | Rollback performed by the core |
| abt_epoch | input | EPOCH_W | Oldest epoch discarded by that rollback |
| abort_req | output | 1 | Abort request, one cycle |
| abort_epoch | output | EPOCH_W | Epoch to roll back to |

## Verification
A record that is lost, has the wrong flag or holds a stale epoch shows up on the first probe that touches its line. The abort then goes missing, appears where none is due, or names the wrong epoch one cycle after the probe. A drifting oldest-epoch counter shows up in the coarse policy's target and in the age ordering across wrap-around. A leaked or stuck free slot shows up as a false or missing full-table abort on the next access that needs a new record. A long stimulus mix that commits and rolls back many times drives the epoch counter through several wraps, so such faults reach the ports within a few cycles of being made.

// File: rtl/sct_pkg.sv
package sct_pkg;
  // distance of an epoch from the oldest live one, modulo 2^w (w <= 8)
  function automatic logic [7:0] ep_age(input logic [7:0] ep,
                                        input logic [7:0] base,
                                        input int unsigned w);
    logic [7:0] diff;
    diff = ep - base;
    return diff & ((8'd1 << w) - 8'd1);
  endfunction
endpackage

// File: rtl/sct_entry_store.sv
module sct_entry_store
  import sct_pkg::*;
#(
  parameter int ADDR_W  = 34,
  parameter int EPOCH_W = 3,
  parameter int DEPTH   = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cmt_valid,
  input  logic                           abt_valid,
  input  logic [EPOCH_W-1:0]             abt_epoch,
  input  logic [EPOCH_W-1:0]             oldest_ep,
  input  logic [DEPTH-1:0]               alloc_oh,
  input  logic [DEPTH-1:0]               merge_oh,
  input  logic [ADDR_W-1:0]              acc_addr,
  input  logic                           acc_write,
  input  logic [EPOCH_W-1:0]             acc_epoch,
  output logic [DEPTH-1:0]               vld_q,
  output logic [DEPTH-1:0][ADDR_W-1:0]   addr_q,
  output logic [DEPTH-1:0][EPOCH_W-1:0]  ep_q,
  output logic [DEPTH-1:0]               wr_q
);
  logic [DEPTH-1:0] vld_d;
  logic [DEPTH-1:0] wr_d;
  logic [7:0]       abt_age;

  assign abt_age = ep_age(8'(abt_epoch), 8'(oldest_ep), EPOCH_W);

  always_comb begin
    vld_d = vld_q;
    wr_d  = wr_q;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld_q[i]) begin
        if (cmt_valid && (ep_q[i] == oldest_ep)) vld_d[i] = 1'b0;
        if (abt_valid &&
            (ep_age(8'(ep_q[i]), 8'(oldest_ep), EPOCH_W) >= abt_age))
          vld_d[i] = 1'b0;
      end
      if (alloc_oh[i]) begin
        vld_d[i] = 1'b1;
        wr_d[i]  = acc_write;
      end
      if (merge_oh[i]) wr_d[i] = wr_q[i] | acc_write;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      wr_q   <= '0;
      addr_q <= '0;
      ep_q   <= '0;
    end else begin
      vld_q <= vld_d;
      wr_q  <= wr_d;
      for (int i = 0; i < DEPTH; i++) begin
        if (alloc_oh[i]) begin
          addr_q[i] <= acc_addr;
          ep_q[i]   <= acc_epoch;
        end
      end
    end
  end
endmodule

// File: rtl/sct_alloc.sv
module sct_alloc #(
  parameter int ADDR_W  = 34,
  parameter int EPOCH_W = 3,
  parameter int DEPTH   = 16
) (
  input  logic                           acc_ok,
  input  logic [ADDR_W-1:0]              acc_addr,
  input  logic [EPOCH_W-1:0]             acc_epoch,
  input  logic [DEPTH-1:0]               vld_q,
  input  logic [DEPTH-1:0][ADDR_W-1:0]   addr_q,
  input  logic [DEPTH-1:0][EPOCH_W-1:0]  ep_q,
  output logic [DEPTH-1:0]               alloc_oh,
  output logic [DEPTH-1:0]               merge_oh,
  output logic                           drop
);
  logic [DEPTH-1:0] same_vec;
  logic [DEPTH-1:0] free_oh;
  logic             free_found;
  logic             any_same;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_cmp
      assign same_vec[g] = vld_q[g] && (addr_q[g] == acc_addr) &&
                           (ep_q[g] == acc_epoch);
    end
  endgenerate

  assign any_same = |same_vec;

  always_comb begin
    free_oh    = '0;
    free_found = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!vld_q[i] && !free_found) begin
        free_oh[i] = 1'b1;
        free_found = 1'b1;
      end
    end
  end

  assign merge_oh = acc_ok ? same_vec : '0;
  assign alloc_oh = (acc_ok && !any_same) ? free_oh : '0;
  assign drop     = acc_ok && !any_same && !free_found;
endmodule

// File: rtl/sct_probe_match.sv
module sct_probe_match
  import sct_pkg::*;
#(
  parameter int ADDR_W     = 34,
  parameter int EPOCH_W    = 3,
  parameter int DEPTH      = 16,
  parameter bit FINE_GRAIN = 1'b1
) (
  input  logic                           prb_valid,
  input  logic [ADDR_W-1:0]              prb_addr,
  input  logic                           prb_excl,
  input  logic [EPOCH_W-1:0]             oldest_ep,
  input  logic [DEPTH-1:0]               vld_q,
  input  logic [DEPTH-1:0][ADDR_W-1:0]   addr_q,
  input  logic [DEPTH-1:0][EPOCH_W-1:0]  ep_q,
  input  logic [DEPTH-1:0]               wr_q,
  output logic                           hit,
  output logic [EPOCH_W-1:0]             target
);
  logic [DEPTH-1:0] hit_vec;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_hit
      assign hit_vec[g] = prb_valid && vld_q[g] && (addr_q[g] == prb_addr) &&
                          (prb_excl || wr_q[g]);
    end

    if (FINE_GRAIN) begin : g_fine
      always_comb begin
        logic [7:0] best_age;
        logic [7:0] cur_age;
        best_age = 8'hFF;
        target   = oldest_ep;
        for (int i = 0; i < DEPTH; i++) begin
          cur_age = ep_age(8'(ep_q[i]), 8'(oldest_ep), EPOCH_W);
          if (hit_vec[i] && (cur_age < best_age)) begin
            best_age = cur_age;
            target   = ep_q[i];
          end
        end
      end
    end else begin : g_basic
      assign target = oldest_ep;
    end
  endgenerate

  assign hit = |hit_vec;
endmodule

// File: rtl/spec_conflict_table.sv
module spec_conflict_table
  import sct_pkg::*;
#(
  parameter int ADDR_W     = 34,
  parameter int EPOCH_W    = 3,
  parameter int DEPTH      = 16,
  parameter bit FINE_GRAIN = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_valid,
  input  logic [ADDR_W-1:0]  acc_addr,
  input  logic               acc_write,
  input  logic [EPOCH_W-1:0] acc_epoch,
  input  logic               prb_valid,
  input  logic [ADDR_W-1:0]  prb_addr,
  input  logic               prb_excl,
  input  logic               cmt_valid,
  input  logic               abt_valid,
  input  logic [EPOCH_W-1:0] abt_epoch,
  output logic               abort_req,
  output logic [EPOCH_W-1:0] abort_epoch
);
  logic [DEPTH-1:0]              vld_q;
  logic [DEPTH-1:0][ADDR_W-1:0]  addr_q;
  logic [DEPTH-1:0][EPOCH_W-1:0] ep_q;
  logic [DEPTH-1:0]              wr_q;
  logic [DEPTH-1:0]              alloc_oh;
  logic [DEPTH-1:0]              merge_oh;
  logic                          drop;
  logic                          acc_ok;
  logic                          prb_hit;
  logic [EPOCH_W-1:0]            prb_target;
  logic [EPOCH_W-1:0]            oldest_q;
  logic [EPOCH_W-1:0]            oldest_d;
  logic                          req_d;
  logic [EPOCH_W-1:0]            ep_d;
  logic                          req_q;
  logic [EPOCH_W-1:0]            ep_q_out;
  logic [7:0]                    age_prb;
  logic [7:0]                    age_acc;

  // table changes from commit/rollback take precedence over new records
  assign acc_ok = acc_valid && !cmt_valid && !abt_valid;

  sct_alloc #(.ADDR_W(ADDR_W), .EPOCH_W(EPOCH_W), .DEPTH(DEPTH)) u_alloc (
    .acc_ok   (acc_ok),
    .acc_addr (acc_addr),
    .acc_epoch(acc_epoch),
    .vld_q    (vld_q),
    .addr_q   (addr_q),
    .ep_q     (ep_q),
    .alloc_oh (alloc_oh),
    .merge_oh (merge_oh),
    .drop     (drop)
  );

  sct_entry_store #(.ADDR_W(ADDR_W), .EPOCH_W(EPOCH_W), .DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmt_valid(cmt_valid),
    .abt_valid(abt_valid),
    .abt_epoch(abt_epoch),
    .oldest_ep(oldest_q),
    .alloc_oh (alloc_oh),
    .merge_oh (merge_oh),
    .acc_addr (acc_addr),
    .acc_write(acc_write),
    .acc_epoch(acc_epoch),
    .vld_q    (vld_q),
    .addr_q   (addr_q),
    .ep_q     (ep_q),
    .wr_q     (wr_q)
  );

  sct_probe_match #(.ADDR_W(ADDR_W), .EPOCH_W(EPOCH_W), .DEPTH(DEPTH),
                    .FINE_GRAIN(FINE_GRAIN)) u_match (
    .prb_valid(prb_valid),
    .prb_addr (prb_addr),
    .prb_excl (prb_excl),
    .oldest_ep(oldest_q),
    .vld_q    (vld_q),
    .addr_q   (addr_q),
    .ep_q     (ep_q),
    .wr_q     (wr_q),
    .hit      (prb_hit),
    .target   (prb_target)
  );

  assign age_prb = ep_age(8'(prb_target), 8'(oldest_q), EPOCH_W);
  assign age_acc = ep_age(8'(acc_epoch), 8'(oldest_q), EPOCH_W);

  always_comb begin
    req_d    = prb_hit || drop;
    oldest_d = cmt_valid ? oldest_q + 1'b1 : oldest_q;
    if (prb_hit && drop)
      ep_d = (age_acc < age_prb) ? acc_epoch : prb_target;
    else if (prb_hit)
      ep_d = prb_target;
    else
      ep_d = acc_epoch;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q    <= 1'b0;
      ep_q_out <= '0;
      oldest_q <= '0;
    end else begin
      req_q    <= req_d;
      oldest_q <= oldest_d;
      if (req_d) ep_q_out <= ep_d;
    end
  end

  assign abort_req   = req_q;
  assign abort_epoch = ep_q_out;
endmodule

// File: rtl/sct_chk.sv
module sct_chk #(
  parameter int ADDR_W     = 34,
  parameter int EPOCH_W    = 3,
  parameter int DEPTH      = 16,
  parameter bit FINE_GRAIN = 1'b1
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          acc_valid,
  input logic                          prb_valid,
  input logic [ADDR_W-1:0]             prb_addr,
  input logic                          prb_excl,
  input logic                          cmt_valid,
  input logic                          abt_valid,
  input logic [EPOCH_W-1:0]            abt_epoch,
  input logic                          abort_req,
  input logic [EPOCH_W-1:0]            abort_epoch,
  input logic [EPOCH_W-1:0]            oldest_ep,
  input logic [DEPTH-1:0]              vld_q,
  input logic [DEPTH-1:0][ADDR_W-1:0]  addr_q
);
  logic any_line;

  always_comb begin
    any_line = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (vld_q[i] && (addr_q[i] == prb_addr)) any_line = 1'b1;
  end

  // R12
  quiet_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!prb_valid && !acc_valid) |=> !abort_req);

  // R2
  excl_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prb_valid && prb_excl && any_line) |=> abort_req);

  // R6
  basic_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!FINE_GRAIN && prb_valid && !acc_valid) |=>
      (!abort_req || (abort_epoch == $past(oldest_ep))));

  // R8
  commit_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid |=> ($countones(vld_q) <= $past($countones(vld_q))));

  // R9
  abort_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abt_valid && !cmt_valid && (abt_epoch == oldest_ep)) |=> (vld_q == '0));
endmodule

bind spec_conflict_table sct_chk #(
  .ADDR_W(ADDR_W), .EPOCH_W(EPOCH_W), .DEPTH(DEPTH), .FINE_GRAIN(FINE_GRAIN)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_valid  (acc_valid),
  .prb_valid  (prb_valid),
  .prb_addr   (prb_addr),
  .prb_excl   (prb_excl),
  .cmt_valid  (cmt_valid),
  .abt_valid  (abt_valid),
  .abt_epoch  (abt_epoch),
  .abort_req  (abort_req),
  .abort_epoch(abort_epoch),
  .oldest_ep  (oldest_q),
  .vld_q      (vld_q),
  .addr_q     (addr_q)
);

// File: tb/spec_conflict_table_tb.sv
module spec_conflict_table_tb;
  localparam int AW = 6;
  localparam int EW = 3;
  localparam int DP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          acc_valid = 0, acc_write = 0, prb_valid = 0, prb_excl = 0;
  logic          cmt_valid = 0, abt_valid = 0;
  logic [AW-1:0] acc_addr = '0, prb_addr = '0;
  logic [EW-1:0] acc_epoch = '0, abt_epoch = '0;
  logic          f_req, b_req;
  logic [EW-1:0] f_ep, b_ep;

  spec_conflict_table #(.ADDR_W(AW), .EPOCH_W(EW), .DEPTH(DP), .FINE_GRAIN(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_write(acc_write), .acc_epoch(acc_epoch), .prb_valid(prb_valid),
    .prb_addr(prb_addr), .prb_excl(prb_excl), .cmt_valid(cmt_valid),
    .abt_valid(abt_valid), .abt_epoch(abt_epoch), .abort_req(f_req), .abort_epoch(f_ep));

  spec_conflict_table #(.ADDR_W(AW), .EPOCH_W(EW), .DEPTH(DP), .FINE_GRAIN(1'b0)) u_dut_basic (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_write(acc_write), .acc_epoch(acc_epoch), .prb_valid(prb_valid),
    .prb_addr(prb_addr), .prb_excl(prb_excl), .cmt_valid(cmt_valid),
    .abt_valid(abt_valid), .abt_epoch(abt_epoch), .abort_req(b_req), .abort_epoch(b_ep));

  int checks = 0;
  int fails  = 0;

  // requirement-level model of the table
  logic          m_v[DP];
  logic [AW-1:0] m_a[DP];
  logic [EW-1:0] m_e[DP];
  logic          m_w[DP];
  logic [EW-1:0] m_old;

  function automatic int age(input logic [EW-1:0] e, input logic [EW-1:0] o);
    return int'(EW'(e - o));
  endfunction

  task automatic check(input string tag, input string who, input logic req,
                       input logic [EW-1:0] ep, input logic xreq,
                       input logic [EW-1:0] xep);
    checks++;
    if (req !== xreq || (xreq && ep !== xep)) begin
      fails++;
      $display("FAIL %s %s: got req=%0b ep=%0d, expected req=%0b ep=%0d",
               tag, who, req, ep, xreq, xep);
    end
  endtask

  task automatic cyc(input string tag,
                     input logic av, input logic [AW-1:0] aa, input logic aw,
                     input logic [EW-1:0] ae,
                     input logic pv, input logic [AW-1:0] pa, input logic px,
                     input logic cv, input logic bv, input logic [EW-1:0] be);
    logic          phit = 0, merged = 0, freed = 0, drop, acc_ok, xreq;
    int            best = 99;
    logic [EW-1:0] pt = '0, xf, xb;
    int            slot = -1;
    for (int i = 0; i < DP; i++)
      if (pv && m_v[i] && m_a[i] == pa && (px || m_w[i])) begin
        phit = 1;
        if (age(m_e[i], m_old) < best) begin best = age(m_e[i], m_old); pt = m_e[i]; end
      end
    acc_ok = av && !cv && !bv;
    for (int i = 0; i < DP; i++)
      if (m_v[i] && m_a[i] == aa && m_e[i] == ae) begin merged = 1; slot = i; end
    if (!merged)
      for (int i = DP - 1; i >= 0; i--) if (!m_v[i]) begin freed = 1; slot = i; end
    drop = acc_ok && !merged && !freed;
    xreq = phit || drop;
    if (phit && drop) begin
      xf = (age(ae, m_old) < best) ? ae : pt;
      xb = (age(ae, m_old) < 0) ? ae : m_old;
    end else if (phit) begin
      xf = pt; xb = m_old;
    end else begin
      xf = ae; xb = ae;
    end
    // model update against pre-cycle state
    for (int i = 0; i < DP; i++)
      if (m_v[i]) begin
        if (cv && m_e[i] == m_old) m_v[i] = 0;
        if (bv && age(m_e[i], m_old) >= age(be, m_old)) m_v[i] = 0;
      end
    if (acc_ok && merged) m_w[slot] = m_w[slot] | aw;
    if (acc_ok && !merged && freed) begin
      m_v[slot] = 1; m_a[slot] = aa; m_e[slot] = ae; m_w[slot] = aw;
    end
    if (cv) m_old = m_old + 1'b1;
    acc_valid = av; acc_addr = aa; acc_write = aw; acc_epoch = ae;
    prb_valid = pv; prb_addr = pa; prb_excl = px;
    cmt_valid = cv; abt_valid = bv; abt_epoch = be;
    @(negedge clk);
    check(tag, "fine", f_req, f_ep, xreq, xf);
    check(tag, "basic", b_req, b_ep, xreq, xb);
    acc_valid = 0; prb_valid = 0; cmt_valid = 0; abt_valid = 0;
  endtask

  task automatic acc(input string t, input logic [AW-1:0] a, input logic w,
                     input logic [EW-1:0] e);
    cyc(t, 1, a, w, e, 0, '0, 0, 0, 0, '0);
  endtask

  task automatic prb(input string t, input logic [AW-1:0] a, input logic x);
    cyc(t, 0, '0, 0, '0, 1, a, x, 0, 0, '0);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: got no finish, expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] lf = 16'hACE1;
    for (int i = 0; i < DP; i++) begin m_v[i] = 0; m_a[i] = '0; m_e[i] = '0; m_w[i] = 0; end
    m_old = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle after reset
    check("R1", "fine", f_req, f_ep, 1'b0, '0);
    check("R1", "basic", b_req, b_ep, 1'b0, '0);

    acc("R7 record", 6'd5, 0, 3'd0);
    prb("R3 shared on read line", 6'd5, 0);
    prb("R2 excl hit", 6'd5, 1);
    prb("R4 miss", 6'd9, 1);
    acc("R7 merge write", 6'd5, 1, 3'd0);
    prb("R3 shared on written line", 6'd5, 0);
    acc("R7", 6'd7, 0, 3'd1);
    acc("R7", 6'd7, 1, 3'd2);
    prb("R5 R6 multi-epoch hit", 6'd7, 1);
    acc("R10 fill", 6'd3, 0, 3'd2);
    acc("R10 full drop", 6'd4, 0, 3'd2);
    acc("R10 merge when full", 6'd3, 1, 3'd2);
    cyc("R10 drop with probe", 1, 6'd4, 0, 3'd1, 1, 6'd7, 1, 0, 0, '0);
    cyc("R11 commit with access and probe", 1, 6'd8, 0, 3'd1, 1, 6'd5, 1, 1, 0, '0);
    prb("R8 committed entry gone", 6'd5, 1);
    prb("R11 access during commit ignored", 6'd8, 1);
    prb("R6 oldest advanced", 6'd7, 1);
    cyc("R9 rollback epoch 2", 0, '0, 0, '0, 1, 6'd3, 1, 0, 1, 3'd2);
    prb("R9 younger dropped", 6'd3, 1);
    prb("R9 older kept", 6'd7, 1);

    // long mixed sweep: wraps the epoch counter many times
    for (int k = 0; k < 3000; k++) begin
      logic cv, bv;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      cv = (lf[13:11] == 3'd0);
      bv = (lf[13:11] == 3'd1);
      cyc("R12 sweep R5 R6 R8 R9 R10", lf[0] | lf[1], AW'(lf[4:2]), lf[5],
          m_old + EW'(lf[7:6]), lf[8], AW'(lf[10:9]) + AW'(lf[2]), lf[14],
          cv, bv, m_old + EW'(lf[15:14]));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule